// File: doc/BRIEF.md
# X2 Clock-Enable Divider Tree

This block derives the timing strobes for a CPU core and six peripherals (timer 0, timer 1, timer 2, the serial port, the counter array and the watchdog) from a single oscillator clock. It does not produce derived clocks. Each output is a one-cycle enable pulse in the oscillator domain. In standard mode a machine cycle spans RATIO_STD oscillator periods (12 by default). In double-speed mode the CPU cycle is half that long. Each peripheral can be kept at the standard rate while the CPU runs fast.

A small control register holds one global double-speed bit and one slow-keep bit per peripheral. A configuration fuse input selects whether the global bit comes out of reset set or clear. A new register value reaches the enable logic only at a rising edge of the internal half-rate clock, so the pulse pattern never breaks mid-cycle. Two inputs from the power controller gate the outputs. The idle input silences the CPU strobe only. The power-down input silences every strobe.

Top module: `x2_clk_tree`

## Requirements
- R1: While rst_n is low at a clock edge, the register is cleared. After that, rd_data reads 0 in bits 7..1 and reads the value of fuse_x2 in bit 0.
- R2: The phase counter is 0 while reset is held. It advances by one at every later clock edge and wraps at 12. With the active global bit (bit 0) clear, cpu_ce and every periph_ce pulse only in phase 11, which is once per 12 clock cycles.
- R3: With the active global bit set, cpu_ce pulses in phases 5 and 11, which is once per 6 clock cycles.
- R4: With the active global bit set, periph_ce[i] pulses every 6 cycles if its slow-keep bit is clear, and every 12 cycles (phase 11 only) if it is set. The slow-keep bits are: bit 1 timer 0, bit 2 timer 1, bit 3 timer 2, bit 4 serial port, bit 5 counter array, bit 6 watchdog. periph_ce[i] belongs to register bit i+1.
- R5: With the active global bit clear, the slow-keep bits have no effect, and every periph_ce equals the ungated CPU strobe.
- R6: A register write changes the active mode only at a clock edge that leaves an even phase (a rising edge of the half-rate clock). Between such edges, the previous mode still drives the outputs.
- R7: If fuse_x2 is high during reset, double-speed mode is active from the first cycle after reset.
- R8: While idle is high, cpu_ce stays low and periph_ce is unaffected.
- R9: While pdown is high, all outputs stay low, and the phase counter keeps advancing.
- R10: Bit 7 of the register always reads 0 and ignores writes. Bits 6..0 read back the written value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_x2 | input | 1 | Fuse selecting double-speed mode after reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| idle | input | 1 | Idle request: gates the CPU strobe |
| pdown | input | 1 | Power-down request: gates all strobes |
| cpu_ce | output | 1 | CPU machine-cycle enable |
| periph_ce | output | 6 | Peripheral enables: timer 0, timer 1, timer 2, serial port, counter array, watchdog |

## Verification
The bench builds the block with RATIO_STD = 12 and six peripherals. A full slow period is therefore only twelve cycles long. Random writes, idle pulses and power-down pulses land in every phase, including the odd phases where a pending mode change must wait one edge. Directed cases measure the 12- and 6-cycle pulse spacing, the fuse-selected reset state and the reserved bit. A cycle-by-cycle reference model then checks the mixed per-peripheral rates.

// File: rtl/x2ct_pkg.sv
package x2ct_pkg;

   localparam int unsigned PER_N = 6;
   localparam int unsigned CTL_W = 8;

   typedef struct packed {
      logic [PER_N-1:0] per_slow;
      logic             glb_fast;
   } ctl_t;

endpackage

// File: rtl/x2ct_ctl_reg.sv
module x2ct_ctl_reg
   import x2ct_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fuse_x2,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output ctl_t             ctl_q,
   output logic [CTL_W-1:0] rd_data
);

   logic unused_rsv;
   assign unused_rsv = wr_data[CTL_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q.per_slow <= '0;
         ctl_q.glb_fast <= fuse_x2;
      end else if (wr_en) begin
         ctl_q.per_slow <= wr_data[PER_N:1];
         ctl_q.glb_fast <= wr_data[0];
      end
   end

   assign rd_data = {1'b0, ctl_q.per_slow, ctl_q.glb_fast};

endmodule

// File: rtl/x2ct_phase_gen.sv
module x2ct_phase_gen #(
   parameter int unsigned RATIO = 12,
   localparam int unsigned HALF = RATIO / 2,
   localparam int unsigned PW   = $clog2(RATIO)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] phase_q,
   output logic          half_rise,
   output logic          tick_slow,
   output logic          tick_fast
);

   localparam logic [PW-1:0] LAST     = PW'(RATIO - 1);
   localparam logic [PW-1:0] MID_LAST = PW'(HALF - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)               phase_q <= '0;
      else if (phase_q == LAST) phase_q <= '0;
      else                      phase_q <= phase_q + 1'b1;
   end

   // the half-rate clock is the phase parity; it rises when leaving an even phase
   assign half_rise = ~phase_q[0];
   assign tick_slow = (phase_q == LAST);
   assign tick_fast = (phase_q == LAST) | (phase_q == MID_LAST);

endmodule

// File: rtl/x2ct_mode_sync.sv
module x2ct_mode_sync
   import x2ct_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fuse_x2,
   input  logic             half_rise,
   input  ctl_t             ctl_q,
   output logic             glb_eff,
   output logic [PER_N-1:0] slow_eff
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_eff  <= fuse_x2;
         slow_eff <= '0;
      end else if (half_rise) begin
         glb_eff  <= ctl_q.glb_fast;
         slow_eff <= ctl_q.per_slow;
      end
   end

endmodule

// File: rtl/x2ct_gate_out.sv
module x2ct_gate_out #(
   parameter int unsigned N = 6
) (
   input  logic         tick_slow,
   input  logic         tick_fast,
   input  logic         glb_eff,
   input  logic [N-1:0] slow_eff,
   input  logic         idle,
   input  logic         pdown,
   output logic         cpu_ce,
   output logic [N-1:0] periph_ce
);

   assign cpu_ce = (glb_eff ? tick_fast : tick_slow) & ~idle & ~pdown;

   for (genvar i = 0; i < N; i++) begin : g_per
      logic fast_sel;
      assign fast_sel     = glb_eff & ~slow_eff[i];
      assign periph_ce[i] = (fast_sel ? tick_fast : tick_slow) & ~pdown;
   end

endmodule

// File: rtl/x2_clk_tree.sv
module x2_clk_tree
   import x2ct_pkg::*;
#(
   parameter int unsigned RATIO_STD = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fuse_x2,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output logic [CTL_W-1:0] rd_data,
   input  logic             idle,
   input  logic             pdown,
   output logic             cpu_ce,
   output logic [PER_N-1:0] periph_ce
);

   localparam int unsigned PW = $clog2(RATIO_STD);

   if (RATIO_STD < 4 || (RATIO_STD % 4) != 0) begin : g_bad_ratio
      $error("x2_clk_tree: RATIO_STD must be a multiple of 4 and at least 4");
   end
   if (CTL_W != PER_N + 2) begin : g_bad_width
      $error("x2_clk_tree: register width must hold global, peripheral and reserved bits");
   end

   ctl_t             ctl_q;
   logic [PW-1:0]    phase_q;
   logic             half_rise;
   logic             tick_slow;
   logic             tick_fast;
   logic             glb_eff;
   logic [PER_N-1:0] slow_eff;

   x2ct_ctl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .fuse_x2 (fuse_x2),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctl_q   (ctl_q),
      .rd_data (rd_data)
   );

   x2ct_phase_gen #(.RATIO(RATIO_STD)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_q   (phase_q),
      .half_rise (half_rise),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast)
   );

   x2ct_mode_sync u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .fuse_x2   (fuse_x2),
      .half_rise (half_rise),
      .ctl_q     (ctl_q),
      .glb_eff   (glb_eff),
      .slow_eff  (slow_eff)
   );

   x2ct_gate_out #(.N(PER_N)) u_gate (
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .glb_eff   (glb_eff),
      .slow_eff  (slow_eff),
      .idle      (idle),
      .pdown     (pdown),
      .cpu_ce    (cpu_ce),
      .periph_ce (periph_ce)
   );

endmodule

// File: rtl/x2_clk_tree_chk.sv
module x2_clk_tree_chk #(
   parameter int unsigned N = 6
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [7:0]   wr_data,
   input logic [7:0]   rd_data,
   input logic         idle,
   input logic         pdown,
   input logic         cpu_ce,
   input logic [N-1:0] periph_ce,
   input logic         glb_eff,
   input logic         phase_lsb
);

   p_cpu_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ce |=> !cpu_ce);

   p_periph_under_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|periph_ce) && !idle) |-> cpu_ce);

   p_std_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_eff && !idle) |-> (periph_ce == {N{cpu_ce}}));

   p_mode_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(glb_eff) |-> phase_lsb);

   p_idle_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !cpu_ce);

   p_pdown_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pdown |-> (!cpu_ce && periph_ce == '0));

   p_write_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == {1'b0, $past(wr_data[6:0])}));

endmodule

bind x2_clk_tree x2_clk_tree_chk #(.N(x2ct_pkg::PER_N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .idle      (idle),
   .pdown     (pdown),
   .cpu_ce    (cpu_ce),
   .periph_ce (periph_ce),
   .glb_eff   (glb_eff),
   .phase_lsb (phase_q[0])
);

// File: tb/x2_clk_tree_test.sv
module x2_clk_tree_test;

   localparam int RATIO = 12;
   localparam int NP    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fuse_x2 = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic          idle = 1'b0;
   logic          pdown = 1'b0;
   logic          cpu_ce;
   logic [NP-1:0] periph_ce;

   int n_checks = 0;
   int n_fail   = 0;

   // reference state, derived from the requirements
   int            m_phase = 0;
   logic [6:0]    m_ctl = '0;
   logic          m_glb = 1'b0;
   logic [NP-1:0] m_slow = '0;

   x2_clk_tree #(.RATIO_STD(RATIO)) uut (
      .clk(clk), .rst_n(rst_n), .fuse_x2(fuse_x2), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .idle(idle), .pdown(pdown),
      .cpu_ce(cpu_ce), .periph_ce(periph_ce)
   );

   always #5 clk = ~clk;

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   function automatic logic exp_cpu();
      logic sl = (m_phase == RATIO - 1);
      logic fa = sl || (m_phase == RATIO / 2 - 1);
      return (m_glb ? fa : sl) & ~idle & ~pdown;
   endfunction

   function automatic logic [NP-1:0] exp_per();
      logic sl = (m_phase == RATIO - 1);
      logic fa = sl || (m_phase == RATIO / 2 - 1);
      logic [NP-1:0] r;
      for (int i = 0; i < NP; i++)
         r[i] = ((m_glb && !m_slow[i]) ? fa : sl) & ~pdown;
      return r;
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         m_phase = 0;
         m_ctl   = {6'b0, fuse_x2};
         m_glb   = fuse_x2;
         m_slow  = '0;
      end else begin
         if (m_phase % 2 == 0) begin
            m_glb  = m_ctl[0];
            m_slow = m_ctl[6:1];
         end
         m_phase = (m_phase == RATIO - 1) ? 0 : m_phase + 1;
         if (wr_en) m_ctl = wr_data[6:0];
      end
   endtask

   task automatic check(input string tag, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic cycle(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag, "cpu_ce", int'(cpu_ce), int'(exp_cpu()));
      check(tag, "periph_ce", int'(periph_ce), int'(exp_per()));
   endtask

   task automatic run(input string tag, input int n);
      for (int i = 0; i < n; i++) cycle(tag);
   endtask

   task automatic write(input string tag, input logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      cycle(tag);
      wr_en = 1'b0;
   endtask

   task automatic do_reset(input logic f);
      fuse_x2 = f;
      rst_n = 1'b0;
      run("R1", 3);
      rst_n = 1'b1;
   endtask

   task automatic measure_gap(input string tag, input int exp);
      int gap = 0;
      int guard = 0;
      while (!cpu_ce && guard < 40) begin cycle(tag); guard++; end
      cycle(tag);
      gap = 1;
      while (!cpu_ce && gap < 40) begin cycle(tag); gap++; end
      check(tag, "cpu_ce spacing", gap, exp);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);

      // R1: reset value with fuse low
      do_reset(1'b0);
      check("R1", "rd_data after reset", int'(rd_data), 0);
      // R2: standard rate everywhere
      run("R2", 2 * RATIO);
      measure_gap("R2", RATIO);

      // R5: slow-keep bits ignored while global bit clear
      write("R5", 8'h7E);
      run("R5", 2 * RATIO);

      // R6 then R3: switch to double speed, change lands on half-rate edge
      write("R6", 8'h01);
      run("R6", RATIO);
      run("R3", 2 * RATIO);
      measure_gap("R3", RATIO / 2);

      // R4: timer 1 (bit 2) and watchdog (bit 6) kept slow
      write("R4", 8'h45);
      run("R4", 3 * RATIO);

      // R8: idle gates only the CPU strobe
      idle = 1'b1;
      run("R8", 2 * RATIO);
      idle = 1'b0;

      // R9: power-down gates everything, phase keeps running
      pdown = 1'b1;
      run("R9", 2 * RATIO);
      pdown = 1'b0;
      run("R9", RATIO);

      // R10: reserved bit reads zero
      write("R10", 8'hFF);
      check("R10", "rd_data", int'(rd_data), 8'h7F);
      write("R10", 8'h80);
      check("R10", "rd_data", int'(rd_data), 8'h00);
      run("R6", RATIO);

      // R7: fuse selects double speed at reset
      do_reset(1'b1);
      check("R7", "rd_data after reset", int'(rd_data), 8'h01);
      run("R7", 2 * RATIO);
      measure_gap("R7", RATIO / 2);

      // random mix
      for (int k = 0; k < 600; k++) begin
         wr_en   = ($urandom_range(0, 7) == 0);
         wr_data = 8'($urandom());
         idle    = ($urandom_range(0, 5) == 0);
         pdown   = ($urandom_range(0, 9) == 0);
         cycle("R4");
         if (wr_en) check("R10", "rd_data", int'(rd_data), int'({1'b0, m_ctl}));
      end
      wr_en = 1'b0; idle = 1'b0; pdown = 1'b0;

      // mid-run reset with fuse low returns to standard rate
      do_reset(1'b0);
      check("R1", "rd_data after reset", int'(rd_data), 0);
      run("R2", 2 * RATIO);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule